// File: doc/BRIEF.md
# Bus Clock Halver with Single Wait-State Acknowledge

This block takes a fast reference clock and produces a bus clock at exactly half its rate for a processor's memory interface. Both edges of the bus clock are launched from rising edges of the fast clock. A toggle register generates the bus clock, and a one-cycle enable marks each bus-clock falling edge. All logic stays in the fast-clock domain.

The same block produces an active-low transfer acknowledge for slow memories. The active-low RAM select is sampled into a first register on a bus-clock falling edge. That register also appears on a test tap. On the next bus-clock falling edge its value moves into the acknowledge register. The acknowledge therefore reaches the processor one bus period later than it would without the block. A memory cycle that would take two bus periods takes three, which is one wait state. The processor samples the acknowledge on bus-clock rising edges, so the acknowledge must be valid half a period before the rising edge that ends the cycle.

A DMA grant input forces the acknowledge inactive at once. An active-low master reset presets the bus clock, the tap and the acknowledge high. A separate auxiliary clock passes straight through as a buffered copy and an inverted copy, and reset has no effect on it.

Top module: `busclk_waitgen`

## Requirements
- R1: After reset is released, `bus_clk` changes level on every rising edge of `clk`, so its frequency is half that of `clk`. Over any 100 fast cycles it shows exactly 50 rising transitions.
- R2: While `master_rst_n` is 0, `bus_clk`, `sel_tap` and `xfer_ack_n` all read 1. After release, `bus_clk` falls on the first rising edge of `clk` that samples `master_rst_n` as 1.
- R3: While `dma_grant` is 1, `xfer_ack_n` reads 1 in the same cycle, whatever the value of `ram_sel_n`.
- R4: `sel_tap` changes only on bus-clock falling edges, that is, fast edges where `bus_clk` goes from 1 to 0. At each such edge it takes the value of `ram_sel_n` sampled there.
- R5: With `dma_grant` 0, `xfer_ack_n` changes only on bus-clock falling edges. At each one it takes the value `sel_tap` held just before that edge.
- R6: A falling edge of `sel_tap` is followed by a falling edge of `xfer_ack_n` exactly two fast cycles (one bus period) later. A rising edge of `sel_tap` is followed in the same way by a rising edge of `xfer_ack_n`. This holds for back-to-back memory cycles.
- R7: `aux_clk_buf` equals `aux_clk` and `aux_clk_inv` equals its inverse at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| master_rst_n | input | 1 | Active-low master reset, preset of outputs |
| ram_sel_n | input | 1 | Active-low RAM select from the processor |
| dma_grant | input | 1 | DMA acknowledge; 1 forces the acknowledge inactive |
| aux_clk | input | 1 | Independent auxiliary clock |
| bus_clk | output | 1 | Half-rate bus clock |
| xfer_ack_n | output | 1 | Active-low transfer acknowledge with one wait state |
| sel_tap | output | 1 | First register of the acknowledge delay chain |
| aux_clk_buf | output | 1 | Buffered auxiliary clock |
| aux_clk_inv | output | 1 | Inverted auxiliary clock |

## Verification
Directed segments come first. Steady select-high traffic separates the divide ratio from any chain activity. Single and back-to-back select-low pulses of several lengths show whether the acknowledge lags the tap by one bus period in both directions. Random runs then mix select transitions at both bus-clock phases, rare DMA grant pulses and short reset pulses. A select change that lands in the wrong phase would be caught in the wrong cycle. A DMA grant held across a falling edge shows that the override is combinational and leaves the chain state intact.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    // Number of bus-clock falling edges between select capture and acknowledge.
    localparam int unsigned CHAIN_DEPTH = 2;

    // Divider output: level of the bus clock and the falling-edge enable.
    typedef struct packed {
        logic level;
        logic fall_en;
    } divtick_t;

    // Shift a new select sample into the chain, oldest value at the top.
    function automatic logic [CHAIN_DEPTH-1:0] shift_in(
        input logic [CHAIN_DEPTH-1:0] cur,
        input logic                   sample
    );
        return {cur[CHAIN_DEPTH-2:0], sample};
    endfunction

endpackage

// File: rtl/busclk_divider.sv
module busclk_divider
    import busclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    output divtick_t tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b1;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // The edge taken while phase is high drives the bus clock low.
    always_comb begin
        tick.level   = phase_q;
        tick.fall_en = phase_q & ~rst;
    end
endmodule

// File: rtl/busclk_wait_chain.sv
module busclk_wait_chain
    import busclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic sel_n,
    output logic tap,
    output logic ack_n
);
    logic [CHAIN_DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '1;
        end else if (step) begin
            stage_q <= shift_in(stage_q, sel_n);
        end
    end

    assign tap   = stage_q[0];
    assign ack_n = stage_q[CHAIN_DEPTH-1];
endmodule

// File: rtl/busclk_aux_buf.sv
module busclk_aux_buf (
    input  logic aux_in,
    output logic aux_pos,
    output logic aux_neg
);
    assign aux_pos = aux_in;
    assign aux_neg = ~aux_in;
endmodule

// File: rtl/busclk_waitgen.sv
module busclk_waitgen
    import busclk_pkg::*;
(
    input  logic clk,
    input  logic master_rst_n,
    input  logic ram_sel_n,
    input  logic dma_grant,
    input  logic aux_clk,
    output logic bus_clk,
    output logic xfer_ack_n,
    output logic sel_tap,
    output logic aux_clk_buf,
    output logic aux_clk_inv
);
    logic     rst;
    divtick_t tick;
    logic     tap_q;
    logic     ack_q;

    assign rst = ~master_rst_n;

    busclk_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    busclk_wait_chain u_chain (
        .clk   (clk),
        .rst   (rst),
        .step  (tick.fall_en),
        .sel_n (ram_sel_n),
        .tap   (tap_q),
        .ack_n (ack_q)
    );

    busclk_aux_buf u_aux (
        .aux_in  (aux_clk),
        .aux_pos (aux_clk_buf),
        .aux_neg (aux_clk_inv)
    );

    // Reset and DMA grant act at once as presets on the outputs.
    assign bus_clk    = tick.level | rst;
    assign sel_tap    = tap_q | rst;
    assign xfer_ack_n = ack_q | rst | dma_grant;
endmodule

// File: rtl/busclk_waitgen_checker.sv
module busclk_waitgen_checker (
    input logic clk,
    input logic master_rst_n,
    input logic dma_grant,
    input logic bus_clk,
    input logic xfer_ack_n,
    input logic sel_tap
);
    // R1: the bus clock alternates on every fast edge outside reset
    a_r1_toggle: assert property (@(posedge clk) disable iff (!master_rst_n)
        $past(master_rst_n) |-> (bus_clk != $past(bus_clk)));

    // R2: reset presets all three outputs high
    a_r2_preset: assert property (@(posedge clk)
        !master_rst_n |-> (bus_clk && sel_tap && xfer_ack_n));

    // R3: DMA grant holds the acknowledge inactive
    a_r3_dma_force: assert property (@(posedge clk)
        dma_grant |-> xfer_ack_n);

    // R4: the tap moves only on bus-clock falling edges
    a_r4_tap_on_fall: assert property (@(posedge clk) disable iff (!master_rst_n)
        ($past(master_rst_n) && (sel_tap != $past(sel_tap)))
            |-> ($past(bus_clk) && !bus_clk));

    // R5: the acknowledge moves only on bus-clock falling edges
    a_r5_ack_on_fall: assert property (@(posedge clk) disable iff (!master_rst_n)
        ($past(master_rst_n) && !dma_grant && !$past(dma_grant)
            && (xfer_ack_n != $past(xfer_ack_n)))
            |-> ($past(bus_clk) && !bus_clk));

    // R5: at a falling edge the acknowledge takes the previous tap value
    a_r5_ack_from_tap: assert property (@(posedge clk) disable iff (!master_rst_n)
        ($past(master_rst_n) && $past(bus_clk) && !bus_clk && !dma_grant)
            |-> (xfer_ack_n == $past(sel_tap)));
endmodule

bind busclk_waitgen busclk_waitgen_checker u_checker (
    .clk          (clk),
    .master_rst_n (master_rst_n),
    .dma_grant    (dma_grant),
    .bus_clk      (bus_clk),
    .xfer_ack_n   (xfer_ack_n),
    .sel_tap      (sel_tap)
);

// File: tb/busclk_waitgen_bench.sv
`timescale 1ns/1ps
module busclk_waitgen_bench;
    logic clk = 1'b0;
    logic master_rst_n = 1'b0;
    logic ram_sel_n = 1'b1;
    logic dma_grant = 1'b0;
    logic aux_clk = 1'b0;
    logic bus_clk, xfer_ack_n, sel_tap, aux_clk_buf, aux_clk_inv;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    busclk_waitgen u_busclk_waitgen (
        .clk          (clk),
        .master_rst_n (master_rst_n),
        .ram_sel_n    (ram_sel_n),
        .dma_grant    (dma_grant),
        .aux_clk      (aux_clk),
        .bus_clk      (bus_clk),
        .xfer_ack_n   (xfer_ack_n),
        .sel_tap      (sel_tap),
        .aux_clk_buf  (aux_clk_buf),
        .aux_clk_inv  (aux_clk_inv)
    );

    // Reference state derived from R1, R2, R4, R5
    logic m_phase = 1'b1, m_tap = 1'b1, m_ack = 1'b1;
    always @(posedge clk) begin
        if (!master_rst_n) begin
            m_phase <= 1'b1; m_tap <= 1'b1; m_ack <= 1'b1;
        end else begin
            if (m_phase) begin
                m_tap <= ram_sel_n;
                m_ack <= m_tap;
            end
            m_phase <= ~m_phase;
        end
    end

    function automatic logic exp_div(input logic ph, input logic rn);
        return ph | ~rn;
    endfunction
    function automatic logic exp_ack(input logic a, input logic d, input logic rn);
        return a | d | ~rn;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Edge timing of tap vs acknowledge (R6), counted in fast cycles
    int cyc = 0;
    int tap_fall_at = -1, tap_rise_at = -1;
    logic prev_tap = 1'b1, prev_ack = 1'b1, prev_dma = 1'b0, prev_rn = 1'b0;
    int rise_cnt = 0;
    logic prev_div = 1'b1;

    task automatic sample_all();
        check("R1 bus_clk", bus_clk, exp_div(m_phase, master_rst_n));
        check("R4 sel_tap", sel_tap, m_tap | ~master_rst_n);
        check("R5 xfer_ack_n", xfer_ack_n, exp_ack(m_ack, dma_grant, master_rst_n));
        if (dma_grant) check("R3 dma forces ack high", xfer_ack_n, 1'b1);
        if (!master_rst_n) begin
            check("R2 preset div", bus_clk, 1'b1);
            check("R2 preset tap", sel_tap, 1'b1);
            check("R2 preset ack", xfer_ack_n, 1'b1);
        end
        check("R7 aux buf", aux_clk_buf, aux_clk);
        check("R7 aux inv", aux_clk_inv, ~aux_clk);
        if (master_rst_n && prev_rn && !dma_grant && !prev_dma) begin
            if (prev_tap && !sel_tap) tap_fall_at = cyc;
            if (!prev_tap && sel_tap) tap_rise_at = cyc;
            if (prev_ack && !xfer_ack_n && tap_fall_at >= 0)
                check("R6 ack fall lag", 1'((cyc - tap_fall_at) == 2), 1'b1);
            if (!prev_ack && xfer_ack_n && tap_rise_at >= 0)
                check("R6 ack rise lag", 1'((cyc - tap_rise_at) == 2), 1'b1);
        end else begin
            tap_fall_at = -1; tap_rise_at = -1;
        end
        if (!prev_div && bus_clk) rise_cnt++;
        prev_div = bus_clk;
        prev_tap = sel_tap; prev_ack = xfer_ack_n;
        prev_dma = dma_grant; prev_rn = master_rst_n;
        cyc++;
    endtask

    // One fast cycle: sample 2 ns after the edge, drive new inputs at 4 ns
    task automatic step(input logic rn, input logic sel, input logic dma);
        @(posedge clk);
        #2;
        sample_all();
        #2;
        master_rst_n = rn; ram_sel_n = sel; dma_grant = dma;
        aux_clk = $urandom_range(0, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset phase (R2)
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        // Divide ratio over 100 cycles (R1)
        rise_cnt = 0;
        for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b0);
        check("R1 rising count per 100 cycles", 1'(rise_cnt == 50), 1'b1);
        // Back-to-back memory cycles with differing select lengths (R6)
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 4 + k; i++) step(1'b1, 1'b0, 1'b0);
            for (int i = 0; i < 1 + (k % 3); i++) step(1'b1, 1'b1, 1'b0);
        end
        // DMA grant over a pending acknowledge (R3)
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);
        // Reset mid-transfer (R2)
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic sel, dma, rn;
            sel = ($urandom_range(0, 3) != 0) ? ram_sel_n : ~ram_sel_n;
            dma = ($urandom_range(0, 19) == 0);
            rn  = ($urandom_range(0, 199) != 0);
            step(rn, sel, dma);
        end
        step(1'b1, 1'b1, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule